// File: doc/BRIEF.md
# Register-Pair Immediate Add/Subtract Unit

This unit adds a small unsigned constant to, or subtracts it from, a 16-bit value held as two adjacent bytes in a byte-wide register file. A two-bit selector picks one of four even-aligned pairs (low byte at index 24, 26, 28 or 30, high byte one index above). The unit has one read port and one write port to the register file and works on one byte per cycle.

After a start pulse is accepted, the first cycle reads, updates and writes back the low byte with the constant. The second cycle does the same for the high byte, using only the carry or borrow left by the first. In the cycle after that, the unit raises a one-cycle done pulse and presents the new zero, carry, negative, overflow and sign flags. The half-carry flag is not produced and so is never changed. The flags keep their values until the next operation completes.

Top module: `pair_imm_unit`

## Requirements
- R1: Pair select code p (0..3) addresses the low byte at register index 24+2p and the high byte at index 25+2p. No other register index is ever written.
- R2: In add mode (isSub=0), the pair is replaced by (pair + imm) mod 65536, with imm an unsigned 6-bit value 0..63.
- R3: In subtract mode (isSub=1), the pair is replaced by (pair - imm) mod 65536.
- R4: The start pulse is taken on a clock edge while idle. The low byte is written on the next edge and the high byte on the edge after that. done is high for exactly the one cycle that follows the high-byte write.
- R5: flagZ is 1 exactly when the whole 16-bit result is zero.
- R6: flagC is the carry out of bit 15 (add) or the borrow out of bit 15 (subtract, set when imm exceeds the old pair value). flagN equals bit 15 of the result.
- R7: flagV is 1 for add when bit 15 goes from 0 to 1, and for subtract when bit 15 goes from 1 to 0. flagS equals flagN XOR flagV.
- R8: A start pulse that arrives while busy is high is ignored. The running operation finishes unchanged and no other pair is touched.
- R9: The flag outputs change only in a cycle where done is high. There is no half-carry output, so that flag is left unmodified.
- R10: After reset, done, busy, rfWrEn and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| isSub | input | 1 | 0 = add, 1 = subtract |
| pairSel | input | 2 | Pair code, 0..3 maps to low index 24/26/28/30 |
| imm | input | 6 | Unsigned constant 0..63 |
| rfRdAddr | output | 5 | Register file read index |
| rfRdData | input | 8 | Register file read data (combinational) |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 5 | Register file write index |
| rfWrData | output | 8 | Register file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flagZ | output | 1 | Zero |
| flagC | output | 1 | Carry / borrow |
| flagN | output | 1 | Negative |
| flagV | output | 1 | Two's-complement overflow |
| flagS | output | 1 | Sign (N xor V) |

## Verification
A wrong latched carry or borrow shows up as a wrong high byte in the register file on the second write edge, and as a wrong carry and overflow in the done cycle, two edges after the start. A wrong latched pair base shows as a write to the wrong index on the very first write edge. A corrupted low-byte zero record appears only in flagZ for results whose high byte is zero. So the tests include a 0x00FF + 1 style carry into a zero high byte, and a subtraction from zero. A start that is taken while busy shows as a change to a second pair, or as a third write enable.

// File: rtl/pairop_pkg.sv
package pairop_pkg;
  parameter int DATA_W   = 8;
  parameter int IMM_W    = 6;
  parameter int ADDR_W   = 5;
  parameter int SEL_W    = 2;
  parameter int BASE_IDX = 24;

  typedef struct packed {
    logic capture;
    logic doLow;
    logic doHigh;
  } ctrl_t;
endpackage

// File: rtl/pairop_ctrl.sv
module pairop_ctrl
  import pairop_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_LOW;
      ST_LOW:  stateNext = ST_HIGH;
      ST_HIGH: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_HIGH);
    end
  end

  always_comb begin
    ctrl.capture = (state == ST_IDLE) && start;
    ctrl.doLow   = (state == ST_LOW);
    ctrl.doHigh  = (state == ST_HIGH);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pairop_datapath.sv
module pairop_datapath
  import pairop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic              isSub,
  input  logic [SEL_W-1:0]  pairSel,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagN,
  output logic              flagV,
  output logic              flagS
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic              opSub;
  logic [ADDR_W-1:0] baseIdx;
  logic [IMM_W-1:0]  immReg;
  logic              carryReg;
  logic              lowZero;

  logic [DATA_W-1:0] operandB;
  logic [DATA_W:0]   sumExt;
  logic [ADDR_W-1:0] curIdx;
  logic              newN, newV;

  // operand B: constant in the low cycle, only the carry/borrow in the high cycle
  always_comb begin
    if (ctrl.doLow) operandB = {{PAD_W{1'b0}}, immReg};
    else            operandB = {{(DATA_W-1){1'b0}}, carryReg};
    if (opSub) sumExt = {1'b0, rfRdData} - {1'b0, operandB};
    else       sumExt = {1'b0, rfRdData} + {1'b0, operandB};
  end

  assign curIdx   = baseIdx + {{(ADDR_W-1){1'b0}}, ctrl.doHigh};
  assign rfRdAddr = curIdx;
  assign rfWrAddr = curIdx;
  assign rfWrEn   = ctrl.doLow | ctrl.doHigh;
  assign rfWrData = sumExt[DATA_W-1:0];

  assign newN = sumExt[DATA_W-1];
  assign newV = opSub ? ( rfRdData[DATA_W-1] & ~newN)
                      : (~rfRdData[DATA_W-1] &  newN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opSub    <= 1'b0;
      baseIdx  <= ADDR_W'(BASE_IDX);
      immReg   <= '0;
      carryReg <= 1'b0;
      lowZero  <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
      flagN    <= 1'b0;
      flagV    <= 1'b0;
      flagS    <= 1'b0;
    end else begin
      if (ctrl.capture) begin
        opSub   <= isSub;
        baseIdx <= ADDR_W'(BASE_IDX) + ADDR_W'({pairSel, 1'b0});
        immReg  <= imm;
      end
      if (ctrl.doLow) begin
        carryReg <= sumExt[DATA_W];
        lowZero  <= (sumExt[DATA_W-1:0] == '0);
      end
      if (ctrl.doHigh) begin
        flagZ <= lowZero && (sumExt[DATA_W-1:0] == '0);
        flagC <= sumExt[DATA_W];
        flagN <= newN;
        flagV <= newV;
        flagS <= newN ^ newV;
      end
    end
  end
endmodule

// File: rtl/pair_imm_unit.sv
module pair_imm_unit
  import pairop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isSub,
  input  logic [SEL_W-1:0]  pairSel,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              busy,
  output logic              done,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagN,
  output logic              flagV,
  output logic              flagS
);
  ctrl_t ctrl;

  pairop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  pairop_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .isSub(isSub), .pairSel(pairSel), .imm(imm),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .flagZ(flagZ), .flagC(flagC), .flagN(flagN), .flagV(flagV), .flagS(flagS)
  );
endmodule

// File: rtl/pairop_checker.sv
module pairop_checker
  import pairop_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rfWrEn,
  input logic [ADDR_W-1:0] rfWrAddr,
  input logic [4:0]        flags
);
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrAddr >= ADDR_W'(BASE_IDX)) && (rfWrAddr <= ADDR_W'(BASE_IDX + 7))); // R1
  AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && !rfWrAddr[0]) |=> (rfWrEn && rfWrAddr[0])); // R4
  AST_DONE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && rfWrAddr[0]) |=> (done && !rfWrEn)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && rfWrEn && rfWrAddr[0]) |=> !busy); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(flags)); // R9
  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flags[0] == (flags[1] ^ flags[2]))); // R7
endmodule

bind pair_imm_unit pairop_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
  .flags({flagZ, flagC, flagN, flagV, flagS})
);

// File: tb/pair_imm_unit_tb.sv
module pair_imm_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, isSub = 1'b0;
  logic [1:0] pairSel = 2'd0;
  logic [5:0] imm = 6'd0;
  logic [4:0] rfRdAddr, rfWrAddr;
  logic [7:0] rfRdData, rfWrData;
  logic rfWrEn, busy, done, flagZ, flagC, flagN, flagV, flagS;
  logic [7:0] rf [32];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pair_imm_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isSub(isSub), .pairSel(pairSel),
    .imm(imm), .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .busy(busy), .done(done),
    .flagZ(flagZ), .flagC(flagC), .flagN(flagN), .flagV(flagV), .flagS(flagS)
  );

  assign rfRdData = rf[rfRdAddr];
  always @(posedge clk) if (rfWrEn) rf[rfWrAddr] <= rfWrData;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pairVal(input int sel);
    return {rf[25+2*sel], rf[24+2*sel]};
  endfunction

  task automatic setPair(input int sel, input logic [15:0] v);
    rf[24+2*sel] = v[7:0];
    rf[25+2*sel] = v[15:8];
  endtask

  // run one operation; optionally inject a second start while busy
  task automatic runOp(input bit sub, input int sel, input int k, input bit inject);
    logic [15:0] oldV, expV, otherV;
    logic [16:0] ext;
    logic eC, eN, eV, eZ;
    int other;
    other = (sel + 1) % 4;
    oldV = pairVal(sel);
    otherV = pairVal(other);
    if (sub) ext = {1'b0, oldV} - 17'(k);
    else     ext = {1'b0, oldV} + 17'(k);
    expV = ext[15:0];
    eC = ext[16];
    eN = expV[15];
    eV = sub ? (oldV[15] & ~expV[15]) : (~oldV[15] & expV[15]);
    eZ = (expV == 16'h0);
    @(negedge clk);
    start = 1'b1; isSub = sub; pairSel = 2'(sel); imm = 6'(k);
    @(negedge clk);
    start = 1'b0;
    check(rfWrEn && rfWrAddr == 5'(24 + 2*sel), "R1/R4 low write", {27'(0), rfWrAddr}, 24 + 2*sel);
    if (inject) begin
      start = 1'b1; isSub = ~sub; pairSel = 2'(other); imm = 6'd33;
    end
    @(negedge clk);
    start = 1'b0;
    check(rfWrEn && rfWrAddr == 5'(25 + 2*sel), "R1/R4 high write", {27'(0), rfWrAddr}, 25 + 2*sel);
    @(negedge clk);
    check(done && !rfWrEn, "R4 done", {30'(0), done, rfWrEn}, 2);
    check(pairVal(sel) == expV, sub ? "R3 result" : "R2 result", pairVal(sel), expV);
    check(flagZ == eZ, "R5 zero", flagZ, eZ);
    check(flagC == eC && flagN == eN, "R6 carry/neg", {flagC, flagN}, {eC, eN});
    check(flagV == eV && flagS == (eN ^ eV), "R7 ovf/sign", {flagV, flagS}, {eV, eN ^ eV});
    @(negedge clk);
    check(!done && !busy && !rfWrEn, "R4 done one cycle", {done, busy, rfWrEn}, 0);
    check(flagZ == eZ && flagC == eC && flagV == eV, "R9 flags hold", {flagZ, flagC, flagV}, {eZ, eC, eV});
    if (inject) check(pairVal(other) == otherV, "R8 busy start ignored", pairVal(other), otherV);
  endtask

  task automatic testReset();
    check(!done && !busy && !rfWrEn, "R10 control reset", {done, busy, rfWrEn}, 0);
    check({flagZ, flagC, flagN, flagV, flagS} == 5'b0, "R10 flags reset",
          {flagZ, flagC, flagN, flagV, flagS}, 0);
  endtask

  task automatic testPlainAdd();
    setPair(0, 16'h1234); runOp(1'b0, 0, 5, 1'b0);
  endtask

  task automatic testCarryChain();
    setPair(1, 16'h00FF); runOp(1'b0, 1, 1, 1'b0);   // R2 low carry into high
    setPair(2, 16'hFFC1); runOp(1'b0, 2, 63, 1'b0);  // R5 wrap to zero, R6 carry out
  endtask

  task automatic testSigned();
    setPair(3, 16'h7FFF); runOp(1'b0, 3, 1, 1'b0);   // R7 add overflow
    setPair(0, 16'h8000); runOp(1'b1, 0, 1, 1'b0);   // R7 subtract overflow
  endtask

  task automatic testSubtract();
    setPair(1, 16'h0100); runOp(1'b1, 1, 1, 1'b0);   // R3 borrow across bytes
    setPair(2, 16'h0000); runOp(1'b1, 2, 63, 1'b0);  // R6 borrow out
    setPair(3, 16'h0020); runOp(1'b1, 3, 32, 1'b0);  // R5 exact zero
    setPair(0, 16'h4567); runOp(1'b1, 0, 0, 1'b0);   // zero constant
  endtask

  task automatic testBusyStart();
    setPair(2, 16'h0A0A); setPair(3, 16'h5555); runOp(1'b0, 2, 17, 1'b1); // R8
  endtask

  task automatic testUntouched();
    logic [7:0] snap [32];
    for (int i = 0; i < 32; i++) snap[i] = rf[i];
    runOp(1'b0, 1, 9, 1'b0);
    for (int i = 0; i < 32; i++)
      if (i != 26 && i != 27) check(rf[i] == snap[i], "R1 other regs", rf[i], snap[i]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlainAdd();
    testCarryChain();
    testSigned();
    testSubtract();
    testBusyStart();
    testUntouched();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule